// File: doc/BRIEF.md
# Narrowing High-Half Add/Subtract Unit

This datapath treats two 128-bit operands as packed double-width lanes. Lane by lane, it adds or subtracts them, and it can add a rounding constant. From each double-width result it keeps the upper half. The narrowed lanes pack into a 64-bit value. A half-select input then places that value into the low or the high half of a 128-bit destination. The rest of the destination is either cleared or taken from the previous destination value supplied on the inputs.

A caller presents the operands, the previous destination and the control bits together with a valid strobe. One clock later the merged destination appears, with a valid flag. A size code with no defined element width sets an error flag and returns the previous destination without change. Saturating and widening forms are not part of this block.

Top module: `narrow_hi_unit`

## Requirements
- R1: The size code `lane_sz` selects the narrow element width E = 8 << `lane_sz` bits for codes 0, 1 and 2. Source lanes are 2E bits wide, and there are 64/E lanes, with lane i occupying operand bits [i*2E +: 2E].
- R2: With `sub_en`=0 and `rnd_en`=0, narrowed lane i is bits [2E-1:E] of (lane i of `op_a` + lane i of `op_b`) modulo 2^(2E). It is placed at bits [i*E +: E] of the 64-bit narrowed value.
- R3: With `sub_en`=1, the lane operation is `op_a` lane minus `op_b` lane, modulo 2^(2E), instead of the sum.
- R4: With `rnd_en`=1, the constant 1 << (E-1) is added to each lane sum or difference, modulo 2^(2E), before the upper half is taken.
- R5: Each lane wraps within its own 2E bits, and no carry or borrow passes into a neighbouring lane.
- R6: With `hi_sel`=0, the narrowed value is written to `dst_out[63:0]` and `dst_out[127:64]` is cleared to zero.
- R7: With `hi_sel`=1, the narrowed value is written to `dst_out[127:64]` and `dst_out[63:0]` equals `dst_prev[63:0]`.
- R8: Size code 3 is reserved. An accepted request with it gives `out_err`=1 and `dst_out` equal to `dst_prev`. For codes 0 to 2, `out_err` is 0.
- R9: `out_valid` is 1 exactly in the cycle after `in_valid` was 1. When no request is accepted, `dst_out` holds its value and `out_err` is 0.
- R10: During reset, `out_valid`, `out_err` and `dst_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| lane_sz | input | 2 | Narrow element size code (3 reserved) |
| sub_en | input | 1 | 1 selects subtraction |
| rnd_en | input | 1 | 1 adds the rounding constant |
| hi_sel | input | 1 | 1 writes the high destination half |
| op_a | input | 128 | First operand, double-width lanes |
| op_b | input | 128 | Second operand, double-width lanes |
| dst_prev | input | 128 | Previous destination value |
| dst_out | output | 128 | Merged destination |
| out_valid | output | 1 | Result valid |
| out_err | output | 1 | Reserved size code seen |

## Verification
Every result of this block, whether the merged destination, the valid flag or the error flag, is due exactly one rising edge after the strobed request. Nothing is due at any other latency.

The bench drives each request on a falling edge and applies the same request to a behavioural model at that moment. It compares all three outputs on the next falling edge, after the single register stage has updated. Idle cycles are compared the same way, so any hold or clear of the outputs is checked in the very cycle it matters.

// File: rtl/narrow_hi_unit.sv
module narrow_hi_unit #(
  parameter int DST_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       lane_sz,
  input  logic             sub_en,
  input  logic             rnd_en,
  input  logic             hi_sel,
  input  logic [DST_W-1:0] op_a,
  input  logic [DST_W-1:0] op_b,
  input  logic [DST_W-1:0] dst_prev,
  output logic [DST_W-1:0] dst_out,
  output logic             out_valid,
  output logic             out_err
);
  localparam int HALF_W = DST_W / 2;
  localparam int N_SZ   = 3;

  for (genvar sz = 0; sz < N_SZ; sz++) begin : g_sz
    localparam int EW    = 8 << sz;
    localparam int LANES = HALF_W / EW;
    logic [HALF_W-1:0] nar;
    for (genvar ln = 0; ln < LANES; ln++) begin : g_ln
      logic [2*EW-1:0] la, lb, rc, acc;
      assign la  = op_a[ln*2*EW +: 2*EW];
      assign lb  = op_b[ln*2*EW +: 2*EW];
      assign rc  = rnd_en ? ((2*EW)'(1) << (EW-1)) : '0;
      assign acc = la + (sub_en ? (~lb + (2*EW)'(1)) : lb) + rc;
      assign nar[ln*EW +: EW] = acc[2*EW-1:EW];
    end
  end

  logic              reserved;
  logic [HALF_W-1:0] narrowed;
  logic [DST_W-1:0]  merged;

  assign reserved = (lane_sz == 2'd3);

  always_comb begin
    case (lane_sz)
      2'd0:    narrowed = g_sz[0].nar;
      2'd1:    narrowed = g_sz[1].nar;
      default: narrowed = g_sz[2].nar;
    endcase
  end

  assign merged = hi_sel ? {narrowed, dst_prev[HALF_W-1:0]}
                         : {{HALF_W{1'b0}}, narrowed};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      dst_out   <= '0;
    end else begin
      out_valid <= in_valid;
      out_err   <= in_valid && reserved;
      if (in_valid) dst_out <= reserved ? dst_prev : merged;
    end
  end

  p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_err && $stable(dst_out)));
  p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sz == 2'd3) |=> (out_err && dst_out == $past(dst_prev)));
  p_legal_noerr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sz != 2'd3) |=> !out_err);
  p_low_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sz != 2'd3 && !hi_sel) |=> (dst_out[DST_W-1:HALF_W] == '0));
  p_high_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sz != 2'd3 && hi_sel) |=>
      (dst_out[HALF_W-1:0] == $past(dst_prev[HALF_W-1:0])));
  p_err_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid);
endmodule

// File: tb/narrow_hi_unit_test.sv
`timescale 1ns/1ps
module narrow_hi_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] lane_sz = 2'd0;
  logic sub_en = 1'b0, rnd_en = 1'b0, hi_sel = 1'b0;
  logic [127:0] op_a = '0, op_b = '0, dst_prev = '0;
  logic [127:0] dst_out;
  logic out_valid, out_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [127:0] exp_dst = '0;
  logic exp_valid = 1'b0, exp_err = 1'b0;
  string exp_tag = "R10";

  always #10 clk = ~clk;

  narrow_hi_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_sz(lane_sz),
    .sub_en(sub_en), .rnd_en(rnd_en), .hi_sel(hi_sel),
    .op_a(op_a), .op_b(op_b), .dst_prev(dst_prev),
    .dst_out(dst_out), .out_valid(out_valid), .out_err(out_err)
  );

  function automatic logic [63:0] ref_narrow(input logic [127:0] a, input logic [127:0] b,
                                             input int sz, input bit sb, input bit rd);
    int ew = 8 << sz;
    int n = 64 / ew;
    logic [63:0] res = '0;
    for (int i = 0; i < n; i++) begin
      logic [63:0] x = 64'(a >> (i * 2 * ew));
      logic [63:0] y = 64'(b >> (i * 2 * ew));
      logic [63:0] wmask = (2 * ew == 64) ? '1 : ((64'd1 << (2 * ew)) - 64'd1);
      logic [63:0] emask = (64'd1 << ew) - 64'd1;
      logic [63:0] s = sb ? (x - y) : (x + y);
      if (rd) s = s + (64'd1 << (ew - 1));
      s = s & wmask;
      res = res | (((s >> ew) & emask) << (i * ew));
    end
    return res;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({exp_tag, " valid"}, {127'd0, out_valid}, {127'd0, exp_valid});
      check({exp_tag, " err"}, {127'd0, out_err}, {127'd0, exp_err});
      check({exp_tag, " dst"}, dst_out, exp_dst);
    end
  end

  task automatic drive(input string tag, input bit v, input int sz, input bit sb, input bit rd,
                       input bit up, input logic [127:0] a, input logic [127:0] b,
                       input logic [127:0] p);
    @(negedge clk);
    #1;
    in_valid = v; lane_sz = 2'(sz); sub_en = sb; rnd_en = rd; hi_sel = up;
    op_a = a; op_b = b; dst_prev = p;
    exp_tag = tag;
    exp_valid = v;
    exp_err = v && (sz == 3);
    if (v) begin
      if (sz == 3) exp_dst = p;
      else if (up) exp_dst = {ref_narrow(a, b, sz, sb, rd), p[63:0]};
      else exp_dst = {64'd0, ref_narrow(a, b, sz, sb, rd)};
    end
  endtask

  initial begin
    #5;
    check("R10 reset valid", {127'd0, out_valid}, 128'd0);
    check("R10 reset err", {127'd0, out_err}, 128'd0);
    check("R10 reset dst", dst_out, 128'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive("R1 R2 size0 add", 1, 0, 0, 0, 0, {8{16'h1234}}, {8{16'h0101}}, '1);
    drive("R1 R2 size1 add", 1, 1, 0, 0, 0, {4{32'h1234_5678}}, {4{32'h0001_0001}}, '0);
    drive("R1 R2 size2 add", 1, 2, 0, 0, 0, {2{64'h0123_4567_89ab_cdef}},
          {2{64'h1111_1111_1111_1111}}, '0);
    drive("R3 sub borrow", 1, 0, 1, 0, 0, {8{16'h0000}}, {8{16'h0001}}, '0);
    drive("R3 sub size2", 1, 2, 1, 0, 0, {2{64'h5}}, {2{64'h6}}, '0);
    drive("R4 round below", 1, 0, 0, 1, 0, {8{16'h017f}}, '0, '0);
    drive("R4 round carry", 1, 0, 0, 1, 0, {8{16'h0180}}, '0, '0);
    drive("R4 round size1 sub", 1, 1, 1, 1, 0, {4{32'h0001_0000}}, {4{32'h0000_8000}}, '0);
    drive("R5 lane wrap", 1, 0, 0, 0, 0, {8{16'hffff}}, {8{16'h0001}}, '0);
    drive("R5 wrap mixed", 1, 1, 0, 1, 0, {32'hffff_ffff, 32'h0, 32'hffff_ffff, 32'h0},
          {4{32'h0000_0001}}, '0);
    drive("R6 low clears high", 1, 1, 0, 0, 0, {4{32'h00aa_0000}}, '0, '1);
    drive("R7 high keeps low", 1, 0, 0, 0, 1, {8{16'h3300}}, {8{16'h0100}},
          128'hdead_beef_cafe_f00d_0123_4567_89ab_cdef);
    drive("R7 high size2 round", 1, 2, 0, 1, 1, {2{64'h0000_0000_8000_0000}}, '0,
          128'h5555_5555_5555_5555_aaaa_aaaa_aaaa_aaaa);
    drive("R8 reserved", 1, 3, 0, 0, 0, '1, '1, 128'h0f0f_0f0f_1234_5678_9abc_def0_1111_2222);
    drive("R8 reserved hi", 1, 3, 1, 1, 1, '0, '0, 128'h7777);
    drive("R9 idle", 0, 0, 0, 0, 0, '1, '1, '1);
    drive("R9 idle reserved code", 0, 3, 0, 0, 1, '0, '0, '0);
    drive("R9 back to back", 1, 0, 0, 0, 1, {8{16'h8000}}, {8{16'h8000}}, '1);
    for (int k = 0; k < 200; k++) begin
      drive("R2 random", ($urandom % 4) != 0, int'($urandom % 4), bit'($urandom), bit'($urandom),
            bit'($urandom), {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom});
    end
    drive("R9 final idle", 0, 0, 0, 0, 0, '0, '0, '0);
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule